// File: doc/BRIEF.md
# Return Address Prediction Stack

This block is a small hardware stack that runs beside the in-memory call stack and predicts where each subroutine return will land. Every call event pushes its return PC here, and the memory push happens as usual elsewhere. On a return event the block presents its top entry as the next fetch address in the same cycle, so fetch can carry on without waiting for the memory load. The return also pops the stack.

The memory stack still holds the architecturally correct return address. When that value comes back, the pipeline signals a resolved return with the true target. The block compares it against the prediction it made for the most recent return. On a mismatch it raises a one-cycle mispredict pulse and a redirect PC. The storage is circular. A push to a full stack overwrites the oldest entry and never stalls. A flush input discards every entry.

Top module: `ret_addr_stack`

## Requirements
- R1: While `ret_i` is high and the stack holds at least one entry, `pred_valid_o` is 1 and `pred_pc_o` equals the most recently pushed return PC, combinationally in that same cycle.
- R2: Nested calls are predicted in last-in first-out order. After pushes A then B, two separate returns predict B and then A.
- R3: A return on a non-empty stack removes the top entry at the next clock edge.
- R4: A return on an empty stack gives `pred_valid_o` = 0 and leaves the stack empty. `pred_valid_o` is never 1 without `ret_i`.
- R5: With DEPTH entries, a push to a full stack overwrites the oldest entry and the occupancy stays at DEPTH. After DEPTH+1 pushes, DEPTH returns predict the newest DEPTH values, newest first, and the next return is not valid.
- R6: When a call and a return arrive together, the return is served first and predicts the current top. The call is then pushed, so the new PC replaces the old top and the occupancy does not change. On an empty stack the return predicts nothing and the call is pushed.
- R7: A high `flush_i` empties the stack at the next edge. A call or return in the same cycle is ignored, so the next return is not valid.
- R8: Every return stores a record of its prediction (the valid flag and the PC). One cycle after `resolve_i`, `mispred_o` is 1 for exactly one cycle if a record is held and either its prediction was not valid or its PC differs from `resolve_pc_i`. `redirect_pc_o` then equals `resolve_pc_i`. A matching prediction gives `mispred_o` = 0.
- R9: A resolve consumes the held record. A resolve with no record held gives no mispredict pulse.
- R10: While `rst_ni` is low, and right after it rises, the stack is empty, no record is held, `pred_valid_o` is 0 and `mispred_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empties the stack at the next edge |
| call_i | input | 1 | Call event |
| call_pc_i | input | PC_W | Return PC to push on a call |
| ret_i | input | 1 | Return event |
| pred_valid_o | output | 1 | Prediction valid for the return this cycle |
| pred_pc_o | output | PC_W | Predicted return target (top entry) |
| resolve_i | input | 1 | Resolved return event from the memory stack |
| resolve_pc_i | input | PC_W | True return target |
| mispred_o | output | 1 | One-cycle mispredict pulse |
| redirect_pc_o | output | PC_W | Correct target for the fetch redirect |

## Verification
The bench builds the block with DEPTH=4 and PC_W=16. At that depth, overflow and wrap-around of the circular pointer are reached within a handful of calls. Five pushes followed by five returns exercise overwriting the oldest entry, the full drain in last-in first-out order, and the step to the empty state. The narrow PC keeps the vector table compact while still telling apart every value pushed.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [PTR_W-1:0] top_idx_o,
  output logic             empty_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] tp_q, tp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  stk_op_e          op;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] x);
    return (x == LAST) ? '0 : x + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] dec(input logic [PTR_W-1:0] x);
    return (x == '0) ? LAST : x - 1'b1;
  endfunction

  always_comb begin
    op = OP_NONE;
    if (!flush_i) begin
      unique case ({call_i, ret_i && cnt_q != '0})
        2'b10:   op = OP_PUSH;
        2'b01:   op = OP_POP;
        2'b11:   op = OP_SWAP;
        default: op = OP_NONE;
      endcase
    end
  end

  always_comb begin
    tp_d     = tp_q;
    cnt_d    = cnt_q;
    wr_en_o  = 1'b0;
    wr_idx_o = inc(tp_q);
    unique case (op)
      OP_PUSH: begin
        wr_en_o = 1'b1;
        tp_d    = inc(tp_q);
        cnt_d   = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
      end
      OP_POP: begin
        tp_d  = dec(tp_q);
        cnt_d = cnt_q - 1'b1;
      end
      OP_SWAP: begin
        // pop then push lands on the same slot
        wr_en_o  = 1'b1;
        wr_idx_o = tp_q;
      end
      default: ;
    endcase
    if (flush_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tp_q  <= '0;
      cnt_q <= '0;
    end else begin
      tp_q  <= tp_d;
      cnt_q <= cnt_d;
    end
  end

  assign top_idx_o = tp_q;
  assign empty_o   = (cnt_q == '0);

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R7
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
  // R4
  empty_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && cnt_q == '0) |=> cnt_q == '0);
  // R6
  swap_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i && !flush_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rd_pc_o
);
  logic [PC_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))    ent_q[g] <= wr_pc_i;
    end
  end

  assign rd_pc_o = ent_q[rd_idx_i];
endmodule

// File: rtl/ras_check.sv
module ras_check #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ret_i,
  input  logic            pred_valid_i,
  input  logic [PC_W-1:0] pred_pc_i,
  input  logic            resolve_i,
  input  logic [PC_W-1:0] resolve_pc_i,
  output logic            mispred_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic            rec_vld_q, rec_pv_q;
  logic [PC_W-1:0] rec_pc_q;
  logic            miss;

  assign miss = rec_vld_q && (!rec_pv_q || rec_pc_q != resolve_pc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_vld_q     <= 1'b0;
      rec_pv_q      <= 1'b0;
      rec_pc_q      <= '0;
      mispred_o     <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      mispred_o <= resolve_i && miss;
      if (resolve_i) begin
        redirect_pc_o <= resolve_pc_i;
        rec_vld_q     <= 1'b0;
      end
      // a new return in the same cycle replaces the consumed record
      if (ret_i) begin
        rec_vld_q <= 1'b1;
        rec_pv_q  <= pred_valid_i;
        rec_pc_q  <= pred_pc_i;
      end
    end
  end

  // R8
  mispred_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispred_o |-> $past(resolve_i));
  // R9
  no_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && !rec_vld_q) |=> !mispred_o);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            call_i,
  input  logic [PC_W-1:0] call_pc_i,
  input  logic            ret_i,
  output logic            pred_valid_o,
  output logic [PC_W-1:0] pred_pc_o,
  input  logic            resolve_i,
  input  logic [PC_W-1:0] resolve_pc_i,
  output logic            mispred_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic [PTR_W-1:0] top_idx, wr_idx;
  logic             empty, wr_en;

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .top_idx_o (top_idx),
    .empty_o   (empty),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx)
  );

  ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_pc_i  (call_pc_i),
    .rd_idx_i (top_idx),
    .rd_pc_o  (pred_pc_o)
  );

  assign pred_valid_o = ret_i && !empty;

  ras_check #(.PC_W(PC_W)) u_check (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ret_i         (ret_i && !flush_i),
    .pred_valid_i  (pred_valid_o),
    .pred_pc_i     (pred_pc_o),
    .resolve_i     (resolve_i),
    .resolve_pc_i  (resolve_pc_i),
    .mispred_o     (mispred_o),
    .redirect_pc_o (redirect_pc_o)
  );

  // R4
  pred_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> ret_i);
  // R1
  pred_after_call_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !flush_i) |=> (ret_i |-> pred_valid_o && pred_pc_o == $past(call_pc_i)));
endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int PC_W  = 16;
  localparam int NVEC  = 17;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            flush = 1'b0, call = 1'b0, ret = 1'b0, resolve = 1'b0;
  logic [PC_W-1:0] call_pc = '0, resolve_pc = '0;
  logic            pred_valid, mispred;
  logic [PC_W-1:0] pred_pc, redirect_pc;
  int              checks = 0, errors = 0;
  bit              done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ret_addr_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .call_i(call), .call_pc_i(call_pc),
    .ret_i(ret), .pred_valid_o(pred_valid), .pred_pc_o(pred_pc),
    .resolve_i(resolve), .resolve_pc_i(resolve_pc),
    .mispred_o(mispred), .redirect_pc_o(redirect_pc)
  );

  // {call, call_pc, ret, flush, exp_valid, exp_pc}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 16'h0200, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0200},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0100},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b1, 16'h0300, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 16'h0310, 1'b1, 1'b0, 1'b1, 16'h0300},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0310},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b1, 16'h0320, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0320},
    {1'b1, 16'h0400, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b1, 16'h0500, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000}
  };

  function automatic string req_of(input int i);
    case (i)
      2:       return "R1";
      3:       return "R2";
      4, 5, 9: return "R4";
      7, 8:    return "R6";
      10, 11:  return "R6";
      13, 16:  return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [PC_W-1:0] cpc, input logic r,
                       input logic f, input logic rs, input logic [PC_W-1:0] rpc);
    @(negedge clk);
    call = c; call_pc = cpc; ret = r; flush = f; resolve = rs; resolve_pc = rpc;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    ret = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R10", PC_W'(pred_valid), 0);
    chk("R10", PC_W'(mispred), 0);
    ret = 1'b0;
    rst_n = 1'b1;
    idle();

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][35], VEC[i][34:19], VEC[i][18], VEC[i][17], 1'b0, '0);
      if (VEC[i][18]) begin
        chk(req_of(i), PC_W'(pred_valid), PC_W'(VEC[i][16]));
        if (VEC[i][16]) chk(req_of(i), pred_pc, VEC[i][15:0]);
      end
    end
    idle();

    // R5 overflow: five pushes into four slots
    for (int k = 1; k <= DEPTH + 1; k++) drive(1'b1, PC_W'(16'h10 * k), 1'b0, 1'b0, 1'b0, '0);
    for (int k = DEPTH + 1; k >= 2; k--) begin
      drive(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
      chk("R5", PC_W'(pred_valid), 1);
      chk("R5", pred_pc, PC_W'(16'h10 * k));
    end
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R5", PC_W'(pred_valid), 0);
    idle();

    // R9 resolve with no record: previous ret left a record, consume it first
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h0777);
    idle();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h0888);
    idle();
    chk("R9", PC_W'(mispred), 0);

    // R8 correct prediction
    drive(1'b1, 16'h0A00, 1'b0, 1'b0, 1'b0, '0);
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h0A00);
    idle();
    chk("R8", PC_W'(mispred), 0);

    // R8 no prediction on empty stack
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h0B00);
    idle();
    chk("R8", PC_W'(mispred), 1);
    chk("R8", redirect_pc, 16'h0B00);
    idle();
    chk("R8", PC_W'(mispred), 0);

    // R8 wrong target
    drive(1'b1, 16'h0C00, 1'b0, 1'b0, 1'b0, '0);
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h0C04);
    idle();
    chk("R8", PC_W'(mispred), 1);
    chk("R8", redirect_pc, 16'h0C04);
    // R9 record consumed
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h0D00);
    idle();
    chk("R9", PC_W'(mispred), 0);

    // R10 reset empties a loaded stack
    drive(1'b1, 16'h0E00, 1'b0, 1'b0, 1'b0, '0);
    idle();
    rst_n = 1'b0;
    #2;
    rst_n = 1'b1;
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R10", PC_W'(pred_valid), 0);
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule